// File: doc/BRIEF.md
# Reset Cause and Status Tracker

This block sits beside a small processor core and remembers why the core last restarted or woke. It watches single-cycle pulses from the power-on detector, the external reset pin, the watchdog and the interrupt wake logic. It also watches the sleep and clear-watchdog instructions. From these it keeps two sticky status flags, a time-out flag and a power-down flag, whose pair of values tells firmware which event happened and whether the core was asleep at the time.

On every event the block also produces what the core must load next. It gives a program counter value, which is the reset vector after a reset and the interrupted address plus one after an interrupt wake. It gives the global-interrupt-disable bit and a stack-available bit. It also raises a flag that tells the clock logic to arm the oscillator start-up timer. Every output is registered, so each value appears in the cycle after the event that caused it.

The block keeps its own record of whether the core is asleep. A sleep pulse sets that record and any reset or wake clears it. Instruction execution and interrupt vectoring belong to other blocks.

Top module: `rst_cause_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become `to_flag`=1, `pd_flag`=1, `stk_avail`=1, `gie_dis`=1, `pc_next`=RESET_VEC (0), `pc_load`=0 and `ost_arm`=0, and the core is treated as running.
- R2: One cycle after a power-on pulse, a pin reset while running, or a clear-watchdog pulse while running, both `to_flag` and `pd_flag` are 1.
- R3: One cycle after a pin reset while asleep, or an interrupt wake while asleep, `to_flag` is 1 and `pd_flag` is 0.
- R4: One cycle after a watchdog reset, `to_flag` is 0. `pd_flag` is 1 if the core was running and 0 if it was asleep.
- R5: One cycle after any reset (power-on, pin or watchdog, asleep or not), `pc_load` is 1 for that one cycle, `pc_next` is RESET_VEC and `gie_dis` is 1. The core is then running.
- R6: One cycle after an interrupt wake while asleep, `pc_load` is 1, `pc_next` equals the sampled `pc_cur` plus one (modulo 2^PC_W), `gie_dis` equals the sampled `gie_cur`, and the core is then running.
- R7: `ost_arm` is 1 for exactly one cycle after a power-on pulse and after any event that ends sleep. It stays 0 after pin or watchdog resets taken while running, and in every other cycle.
- R8: A sleep pulse while running clears `pd_flag`, leaves `to_flag` unchanged and puts the core to sleep. An interrupt wake while running is ignored. Sleep and clear-watchdog pulses while asleep are ignored.
- R9: When several pulses arrive in one cycle, only the highest one takes effect. The order, from highest, is power-on, pin reset, watchdog reset, interrupt wake, sleep, clear-watchdog.
- R10: In cycles with no event taking effect, the flags, `gie_dis` and `pc_next` hold their values, `pc_load` and `ost_arm` are 0, and `stk_avail` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| por_pulse | input | 1 | Power-on reset event |
| pin_rst_pulse | input | 1 | External reset pin event |
| wdt_rst_pulse | input | 1 | Watchdog expiry event |
| irq_wake_pulse | input | 1 | Interrupt request that may wake the core |
| sleep_pulse | input | 1 | Sleep instruction executed |
| clrwdt_pulse | input | 1 | Clear-watchdog instruction executed |
| pc_cur | input | PC_W | Program counter of the current instruction |
| gie_cur | input | 1 | Current global-interrupt-disable bit |
| to_flag | output | 1 | Sticky time-out status flag |
| pd_flag | output | 1 | Sticky power-down status flag |
| stk_avail | output | 1 | Stack-available status bit |
| gie_dis | output | 1 | Global-interrupt-disable value to load |
| pc_next | output | PC_W | Program counter value to load |
| pc_load | output | 1 | One-cycle strobe: load `pc_next` now |
| ost_arm | output | 1 | One-cycle request to arm the oscillator start-up timer |

## Verification
The assertions assume that each event input is high for one sampled cycle per event. They also assume that `pc_cur` and `gie_cur` are valid in the cycle an interrupt wake arrives, and that the core takes no instruction pulse while the tracker marks it asleep. The assertions do not rely on the pulses being exclusive, because priority resolution is part of the contract. The stimulus drives every combination of the six pulses, from both the asleep and the running state and with both interrupt-disable values. It moves into the wanted state only through ordinary sleep or pin-reset pulses, so every input stays a one-cycle level set away from the clock edge.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  // Resolved event for one cycle; the encoding order is not relied upon.
  typedef enum logic [2:0] {
    EV_NONE,
    EV_POR,
    EV_PIN,
    EV_WDT,
    EV_WAKE,
    EV_SLEEP,
    EV_CLRWDT
  } rc_event_e;

  // Number of raw event request lines
  localparam int unsigned NUM_REQ = 6;

  // Request line indices, lowest index wins
  localparam int unsigned REQ_POR    = 0;
  localparam int unsigned REQ_PIN    = 1;
  localparam int unsigned REQ_WDT    = 2;
  localparam int unsigned REQ_WAKE   = 3;
  localparam int unsigned REQ_SLEEP  = 4;
  localparam int unsigned REQ_CLRWDT = 5;

  // Flag-level outcome of one resolved event
  typedef struct packed {
    logic upd;      // an event takes effect
    logic to_v;
    logic pd_v;
    logic asleep_v;
    logic load;     // program counter is reloaded
    logic use_wake; // reload value is pc+1 instead of the vector
    logic ost;
  } rc_outcome_t;

endpackage

// File: rtl/rc_event_arbiter.sv
module rc_event_arbiter
  import rst_cause_pkg::*;
(
  input  logic [NUM_REQ-1:0] req,
  input  logic               asleep,
  output rc_event_e          evt
);

  logic [NUM_REQ-1:0] qual;
  logic [NUM_REQ-1:0] grant;

  // Qualify requests by sleep state: a wake needs sleep, instructions need running.
  always_comb begin
    qual             = req;
    qual[REQ_WAKE]   = req[REQ_WAKE]   &  asleep;
    qual[REQ_SLEEP]  = req[REQ_SLEEP]  & ~asleep;
    qual[REQ_CLRWDT] = req[REQ_CLRWDT] & ~asleep;
  end

  // Fixed-priority one-hot grant, lowest index wins
  genvar gi;
  generate
    for (gi = 0; gi < NUM_REQ; gi++) begin : g_grant
      if (gi == 0) begin : g_first
        assign grant[gi] = qual[gi];
      end else begin : g_rest
        assign grant[gi] = qual[gi] & ~(|qual[gi-1:0]);
      end
    end
  endgenerate

  always_comb begin
    evt = EV_NONE;
    unique case (1'b1)
      grant[REQ_POR]:    evt = EV_POR;
      grant[REQ_PIN]:    evt = EV_PIN;
      grant[REQ_WDT]:    evt = EV_WDT;
      grant[REQ_WAKE]:   evt = EV_WAKE;
      grant[REQ_SLEEP]:  evt = EV_SLEEP;
      grant[REQ_CLRWDT]: evt = EV_CLRWDT;
      default:           evt = EV_NONE;
    endcase
  end

endmodule

// File: rtl/rc_status_encoder.sv
module rc_status_encoder
  import rst_cause_pkg::*;
(
  input  rc_event_e   evt,
  input  logic        asleep,
  input  logic        to_cur,
  output rc_outcome_t res
);

  always_comb begin
    res          = '0;
    res.to_v     = to_cur;
    res.pd_v     = 1'b1;
    res.asleep_v = asleep;
    unique case (evt)
      EV_POR: begin
        res.upd = 1'b1; res.to_v = 1'b1; res.pd_v = 1'b1;
        res.asleep_v = 1'b0; res.load = 1'b1; res.ost = 1'b1;
      end
      EV_PIN: begin
        res.upd = 1'b1; res.to_v = 1'b1; res.pd_v = ~asleep;
        res.asleep_v = 1'b0; res.load = 1'b1; res.ost = asleep;
      end
      EV_WDT: begin
        res.upd = 1'b1; res.to_v = 1'b0; res.pd_v = ~asleep;
        res.asleep_v = 1'b0; res.load = 1'b1; res.ost = asleep;
      end
      EV_WAKE: begin
        res.upd = 1'b1; res.to_v = 1'b1; res.pd_v = 1'b0;
        res.asleep_v = 1'b0; res.load = 1'b1; res.use_wake = 1'b1;
        res.ost = 1'b1;
      end
      EV_SLEEP: begin
        res.upd = 1'b1; res.to_v = to_cur; res.pd_v = 1'b0;
        res.asleep_v = 1'b1;
      end
      EV_CLRWDT: begin
        res.upd = 1'b1; res.to_v = 1'b1; res.pd_v = 1'b1;
      end
      default: res.upd = 1'b0;
    endcase
  end

endmodule

// File: rtl/rc_pc_select.sv
module rc_pc_select #(
  parameter int unsigned      PC_W      = 16,
  parameter logic [PC_W-1:0]  RESET_VEC = '0
) (
  input  logic            use_wake,
  input  logic [PC_W-1:0] pc_cur,
  input  logic            gie_cur,
  output logic [PC_W-1:0] pc_val,
  output logic            gie_val
);

  localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

  // Wake resumes after the interrupted instruction; resets go to the vector.
  assign pc_val  = use_wake ? (pc_cur + PC_STEP) : RESET_VEC;
  assign gie_val = use_wake ? gie_cur : 1'b1;

endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker
  import rst_cause_pkg::*;
#(
  parameter int unsigned     PC_W      = 16,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            por_pulse,
  input  logic            pin_rst_pulse,
  input  logic            wdt_rst_pulse,
  input  logic            irq_wake_pulse,
  input  logic            sleep_pulse,
  input  logic            clrwdt_pulse,
  input  logic [PC_W-1:0] pc_cur,
  input  logic            gie_cur,
  output logic            to_flag,
  output logic            pd_flag,
  output logic            stk_avail,
  output logic            gie_dis,
  output logic [PC_W-1:0] pc_next,
  output logic            pc_load,
  output logic            ost_arm
);

  logic [NUM_REQ-1:0] req;
  rc_event_e          evt;
  rc_outcome_t        res;
  logic               asleep_q;
  logic [PC_W-1:0]    pc_val;
  logic               gie_val;

  always_comb begin
    req             = '0;
    req[REQ_POR]    = por_pulse;
    req[REQ_PIN]    = pin_rst_pulse;
    req[REQ_WDT]    = wdt_rst_pulse;
    req[REQ_WAKE]   = irq_wake_pulse;
    req[REQ_SLEEP]  = sleep_pulse;
    req[REQ_CLRWDT] = clrwdt_pulse;
  end

  rc_event_arbiter u_arb (
    .req    (req),
    .asleep (asleep_q),
    .evt    (evt)
  );

  rc_status_encoder u_enc (
    .evt    (evt),
    .asleep (asleep_q),
    .to_cur (to_flag),
    .res    (res)
  );

  rc_pc_select #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_pcsel (
    .use_wake (res.use_wake),
    .pc_cur   (pc_cur),
    .gie_cur  (gie_cur),
    .pc_val   (pc_val),
    .gie_val  (gie_val)
  );

  // Sticky status and sleep record
  always_ff @(posedge clk) begin
    if (rst) begin
      to_flag  <= 1'b1;
      pd_flag  <= 1'b1;
      asleep_q <= 1'b0;
    end else if (res.upd) begin
      to_flag  <= res.to_v;
      pd_flag  <= res.pd_v;
      asleep_q <= res.asleep_v;
    end
  end

  // Load values and one-cycle strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_next   <= RESET_VEC;
      gie_dis   <= 1'b1;
      stk_avail <= 1'b1;
      pc_load   <= 1'b0;
      ost_arm   <= 1'b0;
    end else begin
      pc_load   <= res.load;
      ost_arm   <= res.ost;
      stk_avail <= 1'b1;
      if (res.load) begin
        pc_next <= pc_val;
        gie_dis <= gie_val;
      end
    end
  end

endmodule

// File: rtl/rst_cause_tracker_chk.sv
module rst_cause_tracker_chk #(
  parameter int unsigned     PC_W      = 16,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            por_pulse,
  input logic            pin_rst_pulse,
  input logic            wdt_rst_pulse,
  input logic            irq_wake_pulse,
  input logic            sleep_pulse,
  input logic            clrwdt_pulse,
  input logic [PC_W-1:0] pc_cur,
  input logic            gie_cur,
  input logic            to_flag,
  input logic            pd_flag,
  input logic            stk_avail,
  input logic            gie_dis,
  input logic [PC_W-1:0] pc_next,
  input logic            pc_load,
  input logic            ost_arm,
  input logic            asleep_q
);

  logic any_evt;
  assign any_evt = por_pulse | pin_rst_pulse | wdt_rst_pulse |
                   irq_wake_pulse | sleep_pulse | clrwdt_pulse;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (to_flag && pd_flag && gie_dis && !pc_load && !ost_arm
                    && pc_next == RESET_VEC));

  // R5
  por_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(por_pulse)) |->
      (pc_load && pc_next == RESET_VEC && gie_dis && to_flag && pd_flag && ost_arm));

  // R4
  wdt_to_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wdt_rst_pulse && !por_pulse && !pin_rst_pulse)) |-> !to_flag);

  // R6
  wake_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(irq_wake_pulse && asleep_q && !por_pulse &&
                          !pin_rst_pulse && !wdt_rst_pulse)) |->
      (pc_load && pc_next == $past(pc_cur) + PC_W'(1) && gie_dis == $past(gie_cur)));

  // R7
  ost_with_load_chk: assert property (@(posedge clk) disable iff (rst)
    ost_arm |-> pc_load);

  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(any_evt)) |->
      ($stable(to_flag) && $stable(pd_flag) && $stable(pc_next) && !pc_load && !ost_arm));

  // R10
  stack_avail_chk: assert property (@(posedge clk) disable iff (rst) stk_avail);

endmodule

bind rst_cause_tracker rst_cause_tracker_chk #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_chk (.*);

// File: tb/rst_cause_tracker_test.sv
module rst_cause_tracker_test;

  localparam int PC_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_pulse = 0, pin_rst_pulse = 0, wdt_rst_pulse = 0;
  logic irq_wake_pulse = 0, sleep_pulse = 0, clrwdt_pulse = 0;
  logic [PC_W-1:0] pc_cur = '0;
  logic gie_cur = 1'b0;
  logic to_flag, pd_flag, stk_avail, gie_dis, pc_load, ost_arm;
  logic [PC_W-1:0] pc_next;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic m_asleep = 0, m_to = 1, m_pd = 1, m_gie = 1, m_load = 0, m_ost = 0;
  logic [PC_W-1:0] m_pc = '0;
  string m_tag = "R1";
  string m_pctag = "R1";

  rst_cause_tracker #(.PC_W(PC_W), .RESET_VEC('0)) uut (
    .clk(clk), .rst(rst), .por_pulse(por_pulse), .pin_rst_pulse(pin_rst_pulse),
    .wdt_rst_pulse(wdt_rst_pulse), .irq_wake_pulse(irq_wake_pulse),
    .sleep_pulse(sleep_pulse), .clrwdt_pulse(clrwdt_pulse), .pc_cur(pc_cur),
    .gie_cur(gie_cur), .to_flag(to_flag), .pd_flag(pd_flag), .stk_avail(stk_avail),
    .gie_dis(gie_dis), .pc_next(pc_next), .pc_load(pc_load), .ost_arm(ost_arm));

  always #10 clk = ~clk;

  task automatic chk(string tag, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(m_tag, "to_flag", PC_W'(to_flag), PC_W'(m_to));
    chk(m_tag, "pd_flag", PC_W'(pd_flag), PC_W'(m_pd));
    chk(m_pctag, "pc_load", PC_W'(pc_load), PC_W'(m_load));
    chk(m_pctag, "pc_next", pc_next, m_pc);
    chk(m_pctag, "gie_dis", PC_W'(gie_dis), PC_W'(m_gie));
    chk("R7", "ost_arm", PC_W'(ost_arm), PC_W'(m_ost));
    chk("R10", "stk_avail", PC_W'(stk_avail), PC_W'(1'b1));
  endtask

  // ev bits: 0 por, 1 pin, 2 wdt, 3 wake, 4 sleep, 5 clrwdt
  task automatic cyc(logic [5:0] ev, logic [PC_W-1:0] pcv, logic g);
    string multi;
    @(negedge clk);
    {clrwdt_pulse, sleep_pulse, irq_wake_pulse, wdt_rst_pulse, pin_rst_pulse, por_pulse} = ev;
    pc_cur  = pcv;
    gie_cur = g;
    multi = ($countones(ev) > 1) ? "R9 " : "";
    m_load = 0; m_ost = 0;
    if (ev[0]) begin
      m_to = 1; m_pd = 1; m_pc = '0; m_gie = 1; m_load = 1; m_ost = 1; m_asleep = 0;
      m_tag = {multi, "R2"}; m_pctag = {multi, "R5"};
    end else if (ev[1]) begin
      m_to = 1; m_pd = !m_asleep; m_ost = m_asleep;
      m_tag = {multi, m_asleep ? "R3" : "R2"};
      m_pc = '0; m_gie = 1; m_load = 1; m_asleep = 0; m_pctag = {multi, "R5"};
    end else if (ev[2]) begin
      m_to = 0; m_pd = !m_asleep; m_ost = m_asleep; m_tag = {multi, "R4"};
      m_pc = '0; m_gie = 1; m_load = 1; m_asleep = 0; m_pctag = {multi, "R5"};
    end else if (ev[3] && m_asleep) begin
      m_to = 1; m_pd = 0; m_pc = pcv + 1'b1; m_gie = g; m_load = 1; m_ost = 1;
      m_asleep = 0; m_tag = {multi, "R3"}; m_pctag = {multi, "R6"};
    end else if (ev[4] && !m_asleep) begin
      m_pd = 0; m_asleep = 1; m_tag = {multi, "R8"}; m_pctag = {multi, "R8"};
    end else if (ev[5] && !m_asleep) begin
      m_to = 1; m_pd = 1; m_tag = {multi, "R2"}; m_pctag = {multi, "R10"};
    end else begin
      m_tag   = (ev != 0) ? "R8" : "R10";
      m_pctag = m_tag;
    end
    @(posedge clk);
    #5;
    compare_all();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state visible after the reset edges
    compare_all();
    for (int want = 0; want < 2; want++) begin
      for (int g = 0; g < 2; g++) begin
        for (int ev = 0; ev < 64; ev++) begin
          logic [PC_W-1:0] pcv;
          pcv = (ev == 63) ? '1 : PC_W'(ev * 1031 + g * 7);
          if (want == 1 && !m_asleep) cyc(6'b010000, '0, 1'b0);
          if (want == 0 && m_asleep)  cyc(6'b000010, '0, 1'b0);
          // give status a non-trivial prior value now and then
          if (ev % 5 == 2 && want == 0) cyc(6'b000100, '0, 1'b0);
          if (ev % 5 == 2 && want == 1) begin
            cyc(6'b000100, '0, 1'b0);
            cyc(6'b010000, '0, 1'b0);
          end
          cyc(6'(ev), pcv, g[0]);
          cyc(6'b000000, 16'h1234, ~g[0]);
        end
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule